// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

The controller collects a bank of interrupt sources and drives one active-low interrupt line to a processor. Each source has a control word that selects how its input is detected (high level, low level, rising edge or falling edge) and gives it a priority. An edge source latches a pending flag. A level source is pending while its input is at the selected level. Software can also set or clear any source's latch through command words. Each source is enabled by a mask that software changes only through write-one enable and disable commands.

When an enabled source is pending and no interrupt is in service, the line goes low. The handler reads the vector word, which returns the winning source number times four. That read is the acknowledge: it marks the interrupt as in service, records its number, clears that source's latch and releases the line. The line stays high until the handler writes the end-of-service word. After that write, any enabled source that is still pending drives the line low again.

The register file sits on a simple 32-bit request/response bus. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is always high, so the controller never stalls a request. Each accepted read returns its data one cycle later with a single-cycle `rsp_valid` pulse. The response path has no back-pressure, so the requester must accept the data in that cycle. Writes produce no response.

Top module: `ivc_top`

## Requirements
- R1: After reset every source is masked, `irq_n` is 1, nothing is in service, and every control word reads 0x40 (high level, priority 0).
- R2: Word n*4 (n = 0..31) is the control word of source n. Bits [7:6] hold the trigger type (00 low level, 01 high level, 10 falling edge, 11 rising edge) and bits [2:0] hold the priority. All other bits read as 0.
- R3: Writing 0x120 sets every mask bit whose data bit is 1. Writing 0x124 clears every mask bit whose data bit is 1. Bits written as 0 leave the mask unchanged. The mask reads at 0x114.
- R4: A level source is pending while its input is at the selected level and stops being pending when the input leaves that level. Raw inputs read at 0x100 and the pending vector reads at 0x104.
- R5: An edge source becomes pending on its selected edge and stays pending after the input returns, until it is acknowledged or cleared.
- R6: Among sources that are both pending and enabled, the highest priority value wins and a tie goes to the lower source number. Reading 0x10C returns the winner's number times 4, or 0 when no source is pending and enabled.
- R7: A read of 0x10C that finds a winner acknowledges it. `irq_n` goes to 1, the winner's latch is cleared, and 0x110 returns the winner's number.
- R8: Between an acknowledge and a write of any value to 0x130, `irq_n` stays 1. After that write, `irq_n` is 0 again if an enabled source is pending.
- R9: Writing 0x128 sets the latch of every source whose data bit is 1, and writing 0x12C clears them. A level source is pending while either its latch or its input is active.
- R10: If a selected edge arrives in the same cycle as an acknowledge of that source, the source stays pending. The new edge wins over the clear.
- R11: A masked source never drives `irq_n` and never wins arbitration. 0x118 reads the pending vector ANDed with the mask.
- R12: `req_ready` is always 1. Every accepted read produces exactly one `rsp_valid` pulse in the next cycle. Unmapped words read 0, and writes to them or to read-only words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source inputs, bit n is source n |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always 1) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two things can land on the same edge: an acknowledge that clears a source's latch, and a new selected edge on that same source. The bench raises the input of a rising-edge source in the very cycle it issues the vector read for that source. It then expects the read to return the source's vector, the pending vector to still show the source while it is in service, and, after end of service, the line to fall and a second vector read to return the same source. The arbitration order is checked with tied and untied priorities, including a masked source that has the highest priority.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_FALL = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;

  // word indices (byte address / 4)
  localparam int unsigned W_RAW   = 'h40;
  localparam int unsigned W_PEND  = 'h41;
  localparam int unsigned W_VEC   = 'h43;
  localparam int unsigned W_CUR   = 'h44;
  localparam int unsigned W_MASK  = 'h45;
  localparam int unsigned W_OUT   = 'h46;
  localparam int unsigned W_MSET  = 'h48;
  localparam int unsigned W_MCLR  = 'h49;
  localparam int unsigned W_SSET  = 'h4A;
  localparam int unsigned W_SCLR  = 'h4B;
  localparam int unsigned W_EOS   = 'h4C;
endpackage

// File: rtl/ivc_src_cell.sv
module ivc_src_cell
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  trig_e      trig_i,
  input  logic       set_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic src_q, lvl_q, latch_q, edge_hit, is_level;

  assign is_level = (trig_i == TRG_LOW) || (trig_i == TRG_HIGH);

  always_comb begin
    unique case (trig_i)
      TRG_RISE: edge_hit = src_i & ~src_q;
      TRG_FALL: edge_hit = ~src_i & src_q;
      default:  edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      lvl_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      src_q   <= src_i;
      lvl_q   <= (trig_i == TRG_HIGH) ? src_i : ~src_i;
      // a fresh set or edge wins over any clear in the same cycle
      latch_q <= set_i | edge_hit | (latch_q & ~clr_i);
    end
  end

  assign pend_o = is_level ? (lvl_q | latch_q) : latch_q;

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> latch_q);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> latch_q);
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  act_i,
  input  logic [PRIO_W-1:0] prio_i [N_SRC],
  output logic              win_vld_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare: ties keep the lower number
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    best      = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (act_i[i] && (!win_vld_o || prio_i[i] > best)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        best      = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_n
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam int unsigned WRD_W = ADDR_W - 2;

  trig_e             trig_q [N_SRC];
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [N_SRC-1:0]  mask_q, pend, act, set_v, clr_v, ack_v;
  logic [IDX_W-1:0]  cur_q, win_idx;
  logic              in_svc_q, win_vld;
  logic              wr_fire, rd_fire, aligned, ack_fire, eos_wr;
  logic [WRD_W-1:0]  word;
  logic [DATA_W-1:0] rd_mux, ctl_rd;
  logic [N_SRC-1:0]  wbits;
  logic              unused_wdata;

  assign req_ready    = 1'b1;
  assign wr_fire      = req_valid & req_write;
  assign rd_fire      = req_valid & ~req_write;
  assign aligned      = (req_addr[1:0] == 2'b00);
  assign word         = req_addr[ADDR_W-1:2];
  assign wbits        = req_wdata[N_SRC-1:0];
  assign unused_wdata = ^req_wdata;

  function automatic logic hit(input logic [WRD_W-1:0] w, input int unsigned idx);
    return aligned && (int'(w) == idx);
  endfunction

  // ---------------- per-source detection ----------------
  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      ivc_src_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i[g]),
        .trig_i (trig_q[g]),
        .set_i  (set_v[g]),
        .clr_i  (clr_v[g]),
        .pend_o (pend[g])
      );
    end
  endgenerate

  assign act = pend & mask_q;

  ivc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .act_i     (act),
    .prio_i    (prio_q),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx)
  );

  // ---------------- command decode ----------------
  assign ack_fire = rd_fire && hit(word, W_VEC) && win_vld;
  assign eos_wr   = wr_fire && hit(word, W_EOS);
  assign ack_v    = ack_fire ? (N_SRC'(1) << win_idx) : '0;
  assign set_v    = (wr_fire && hit(word, W_SSET)) ? wbits : '0;
  assign clr_v    = ack_v | ((wr_fire && hit(word, W_SCLR)) ? wbits : '0);

  // ---------------- control words and mask ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) begin
        trig_q[i] <= TRG_HIGH;
        prio_q[i] <= '0;
      end
      mask_q <= '0;
    end else if (wr_fire) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (hit(word, i)) begin
          trig_q[i] <= trig_e'(req_wdata[7:6]);
          prio_q[i] <= req_wdata[PRIO_W-1:0];
        end
      end
      if (hit(word, W_MSET)) mask_q <= mask_q | wbits;
      if (hit(word, W_MCLR)) mask_q <= mask_q & ~wbits;
    end
  end

  // ---------------- service state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_q <= 1'b0;
      cur_q    <= '0;
    end else if (ack_fire) begin
      in_svc_q <= 1'b1;
      cur_q    <= win_idx;
    end else if (eos_wr) begin
      in_svc_q <= 1'b0;
    end
  end

  assign irq_n = ~(win_vld & ~in_svc_q);

  // ---------------- read path ----------------
  always_comb begin
    ctl_rd = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (hit(word, i)) begin
        ctl_rd[7:6]        = trig_q[i];
        ctl_rd[PRIO_W-1:0] = prio_q[i];
      end
    end
  end

  always_comb begin
    rd_mux = ctl_rd;
    if (hit(word, W_RAW))  rd_mux = DATA_W'(src_i);
    if (hit(word, W_PEND)) rd_mux = DATA_W'(pend);
    if (hit(word, W_VEC))  rd_mux = win_vld ? (DATA_W'(win_idx) << 2) : '0;
    if (hit(word, W_CUR))  rd_mux = DATA_W'(cur_q);
    if (hit(word, W_MASK)) rd_mux = DATA_W'(mask_q);
    if (hit(word, W_OUT))  rd_mux = DATA_W'(act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rd_mux;
    end
  end

  // ---------------- assertions ----------------
  p_win_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> act[win_idx]);
  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && hit(word, W_MSET)) |=> ((mask_q & $past(wbits)) == $past(wbits)));
  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && hit(word, W_MCLR)) |=> ((mask_q & $past(wbits)) == '0));
  p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> irq_n);
  p_eos_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eos_wr |=> !in_svc_q);
  p_svc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_q && !eos_wr) |=> in_svc_q);
  p_rsp_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
  p_rsp_none_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid);
endmodule

// File: tb/test_ivc_top.sv
`timescale 1ns/1ps
module test_ivc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] srcs = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_n;
  logic [31:0] rsp_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ivc_top i_ivc_top (
    .clk(clk), .rst_n(rst_n), .src_i(srcs),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_n(irq_n)
  );

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_fail++;
          $display("FAIL %s act=%h exp=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", t, act, e);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(irq_n, 1'b1, "R1 irq_n after reset");
    chk(req_ready, 1'b1, "R12 req_ready");
    rd(12'h000, 32'h40, "R1 ctl0 reset");
    rd(12'h07C, 32'h40, "R1 ctl31 reset");
    rd(12'h114, 32'h0, "R1 mask reset");
    rd(12'h110, 32'h0, "R1 current source reset");
    // R2 field layout
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, 32'hC7, "R2 ctl3 fields only");
    wr(12'h00C, 32'h41);
    rd(12'h00C, 32'h41, "R2 ctl3 rewrite");
    // R3 write-one mask commands
    wr(12'h120, 32'h0000_00F0);
    rd(12'h114, 32'hF0, "R3 mask enable");
    wr(12'h124, 32'h0000_0030);
    rd(12'h114, 32'hC0, "R3 mask disable");
    wr(12'h124, 32'hFFFF_FFFF);
    // R4/R11 high level, masked then enabled
    wr(12'h018, 32'h42);
    srcs[6] = 1'b1; tick();
    chk(irq_n, 1'b1, "R11 masked level quiet");
    rd(12'h100, 32'h40, "R4 raw input");
    rd(12'h104, 32'h40, "R4 pending level");
    rd(12'h118, 32'h0, "R11 output status masked");
    rd(12'h10C, 32'h0, "R11 masked source no vector");
    wr(12'h120, 32'h40);
    chk(irq_n, 1'b0, "R4 enabled level asserts");
    rd(12'h118, 32'h40, "R11 output status enabled");
    rd(12'h10C, 32'd24, "R6 vector src6");
    chk(irq_n, 1'b1, "R7 ack releases irq");
    rd(12'h110, 32'd6, "R7 current source");
    tick();
    chk(irq_n, 1'b1, "R8 held until eos");
    wr(12'h130, 32'h0);
    chk(irq_n, 1'b0, "R8 level still high re-asserts");
    rd(12'h10C, 32'd24, "R6 vector src6 again");
    srcs[6] = 1'b0; tick();
    wr(12'h130, 32'h1234);
    chk(irq_n, 1'b1, "R4 level gone");
    rd(12'h10C, 32'h0, "R6 empty vector");
    // R4 low level
    wr(12'h01C, 32'h01);
    srcs[7] = 1'b1; tick();
    wr(12'h120, 32'h80);
    tick();
    chk(irq_n, 1'b1, "R4 low level inactive when high");
    srcs[7] = 1'b0; tick();
    chk(irq_n, 1'b0, "R4 low level active");
    rd(12'h10C, 32'd28, "R6 vector src7");
    srcs[7] = 1'b1; tick();
    wr(12'h130, 32'h0);
    chk(irq_n, 1'b1, "R4 low level released");
    wr(12'h124, 32'hFFFF_FFFF);
    // R5 rising edge
    wr(12'h028, 32'hC4);
    wr(12'h120, 32'h400);
    srcs[10] = 1'b1; tick();
    srcs[10] = 1'b0; tick(); tick();
    chk(irq_n, 1'b0, "R5 rising edge latched");
    rd(12'h104, 32'h400, "R5 pending after input low");
    rd(12'h10C, 32'd40, "R6 vector src10");
    rd(12'h104, 32'h0, "R7 ack clears edge latch");
    wr(12'h130, 32'h0);
    chk(irq_n, 1'b1, "R5 nothing after eos");
    // R5 falling edge
    srcs[11] = 1'b1; tick();
    wr(12'h02C, 32'h84);
    wr(12'h120, 32'h800);
    tick();
    chk(irq_n, 1'b1, "R5 falling no edge yet");
    srcs[11] = 1'b0; tick();
    chk(irq_n, 1'b0, "R5 falling edge latched");
    rd(12'h10C, 32'd44, "R6 vector src11");
    wr(12'h130, 32'h0);
    chk(irq_n, 1'b1, "R5 falling cleared");
    wr(12'h124, 32'hFFFF_FFFF);
    // R6/R9/R11 arbitration via software set
    wr(12'h004, 32'h42);
    wr(12'h008, 32'h45);
    wr(12'h010, 32'h45);
    wr(12'h024, 32'h47);
    wr(12'h128, 32'h0000_0216);
    rd(12'h104, 32'h216, "R9 software set pending");
    wr(12'h120, 32'h16);
    rd(12'h10C, 32'd8, "R6 tie lower number src2");
    wr(12'h130, 32'h0);
    rd(12'h10C, 32'd16, "R6 next src4");
    wr(12'h130, 32'h0);
    rd(12'h10C, 32'd4, "R6 lowest priority src1");
    wr(12'h130, 32'h0);
    chk(irq_n, 1'b1, "R11 masked prio7 src9 quiet");
    rd(12'h10C, 32'h0, "R11 masked src9 no win");
    wr(12'h12C, 32'h200);
    rd(12'h104, 32'h0, "R9 software clear");
    wr(12'h120, 32'h200);
    wr(12'h128, 32'h200);
    chk(irq_n, 1'b0, "R9 set drives irq");
    wr(12'h12C, 32'h200);
    chk(irq_n, 1'b1, "R9 clear releases irq");
    wr(12'h124, 32'hFFFF_FFFF);
    // R10 edge in the same cycle as its acknowledge
    wr(12'h014, 32'hC3);
    wr(12'h120, 32'h20);
    srcs[5] = 1'b1; tick();
    srcs[5] = 1'b0; tick();
    chk(irq_n, 1'b0, "R10 first edge latched");
    srcs[5] = 1'b1;
    rd(12'h10C, 32'd20, "R10 vector src5");
    chk(irq_n, 1'b1, "R10 in service quiet");
    rd(12'h104, 32'h20, "R10 new edge survives ack");
    wr(12'h130, 32'h0);
    chk(irq_n, 1'b0, "R10 re-asserts after eos");
    rd(12'h10C, 32'd20, "R10 vector src5 again");
    wr(12'h130, 32'h0);
    chk(irq_n, 1'b1, "R10 drained");
    // R12 unmapped and read-only words
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h104, 32'h0, "R12 pending not writable");
    rd(12'h108, 32'h0, "R12 unmapped reads zero");
    rd(12'h002, 32'h0, "R12 unaligned reads zero");
    rd(12'h114, 32'h20, "R12 mask untouched");
    tick(); tick();
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 missing responses act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule